// File: doc/BRIEF.md
# Supply Rail Reset Supervisor with Watchdog

This block watches digitized undervoltage flags for a set of supply rails and drives two kinds of output. One active-low fault line per rail follows its flag with no delay. A single active-low system reset is asserted by any rail fault, by a manual reset request, or by a watchdog expiry. The reset is then held for a reset-timeout period after every cause has gone away. The reset timeout is either a fixed parameter or a value programmed on an input bus.

The watchdog expects the host to toggle its input. Either a rising or a falling edge restarts the count. If no edge arrives within the timeout, the system reset fires. After each reset release the first edge may take up to a longer startup window. The watchdog can be switched off. An active-low margin input overrides everything and drives every output high. The watchdog and manual reset inputs are asynchronous. Both pass through two-flop synchronizers, and the manual reset is also debounced.

Top module: `rail_supervisor`

## Requirements
- R1: While margin_n is high, fault_n[i] is low in the same cycle that rail_uv[i] is 1, and returns high in the same cycle that rail_uv[i] returns to 0.
- R2: While margin_n is high, sys_rst_n is low in any cycle in which any bit of rail_uv is 1.
- R3: A low level on mr_n asserts sys_rst_n, but only once it has been stable for DEBOUNCE cycles after the two synchronizer stages. A low pulse shorter than DEBOUNCE cycles has no effect on sys_rst_n.
- R4: Once every cause is gone, sys_rst_n stays low for exactly the selected timeout T. When the last rail clears, sys_rst_n rises on the T-th rising clock edge after the clear. When mr_n rises, it rises on the (2+DEBOUNCE+T)-th edge.
- R5: tmo_sel=0 selects T=RST_TIMEOUT. tmo_sel=1 selects T=tmo_prog, and a programmed value of 0 acts as 1.
- R6: After rst_n is released, sys_rst_n starts low and rises on the RST_TIMEOUT-th rising edge.
- R7: After sys_rst_n releases with the watchdog enabled and no wdi edge, sys_rst_n falls on the (WD_STARTUP+1)-th edge after release.
- R8: A rising or falling wdi edge outside reset restarts the watchdog with the normal window. With no further edge, sys_rst_n falls on the (WD_TIMEOUT+4)-th edge after wdi changes. Toggling at intervals shorter than WD_TIMEOUT never causes a reset.
- R9: While the reset is asserted the watchdog is held cleared, and wdi edges during that time are ignored. Every release starts a fresh startup window.
- R10: With wd_en=0 the watchdog never asserts sys_rst_n.
- R11: While margin_n is low, every fault_n bit and sys_rst_n read 1 in the same cycle, whatever the rail flags say.
- R12: A reset caused by watchdog expiry is held low for exactly T cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| rail_uv | input | NUM_RAILS | Undervoltage flag per rail, 1 = below threshold |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| margin_n | input | 1 | Override, active low: forces all outputs high |
| wdi | input | 1 | Watchdog kick, either edge counts, asynchronous |
| wd_en | input | 1 | Watchdog enable |
| tmo_sel | input | 1 | 0 = fixed reset timeout, 1 = programmed timeout |
| tmo_prog | input | CNT_W | Programmed reset timeout in cycles |
| fault_n | output | NUM_RAILS | Per-rail fault line, active low |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Rail effects on fault_n and sys_rst_n are combinational, so they are checked 1 ns after the stimulus. The margin override is checked the same way. Every timed result is due a fixed number of rising edges after the stimulus, with no slack:
- a rail release after T edges;
- a manual release after 2+DEBOUNCE+T edges;
- a startup expiry after WD_STARTUP+1 edges;
- a post-kick expiry after WD_TIMEOUT+4 edges.

The bench drives each stimulus at a falling edge and counts falling edges until sys_rst_n changes. Each count is compared for equality with the expected number.

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
  parameter int NUM_RAILS   = 4,
  parameter int CNT_W       = 16,
  parameter int RST_TIMEOUT = 1000,
  parameter int WD_TIMEOUT  = 4000,
  parameter int WD_STARTUP  = 20000,
  parameter int DEBOUNCE    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] rail_uv,
  input  logic                 mr_n,
  input  logic                 margin_n,
  input  logic                 wdi,
  input  logic                 wd_en,
  input  logic                 tmo_sel,
  input  logic [CNT_W-1:0]     tmo_prog,
  output logic [NUM_RAILS-1:0] fault_n,
  output logic                 sys_rst_n
);
  localparam int DB_W = $clog2(DEBOUNCE + 1);

  logic            mr_s1, mr_s2, mr_db;
  logic [DB_W-1:0] db_cnt;
  logic            w_s1, w_s2, w_s3;
  logic            rst_active, wd_first;
  logic [CNT_W-1:0] rst_cnt, wd_cnt;

  wire             any_uv    = |rail_uv;
  wire             wd_edge   = w_s2 ^ w_s3;
  wire [CNT_W-1:0] tmo       = tmo_sel ? tmo_prog : CNT_W'(RST_TIMEOUT);
  wire [CNT_W-1:0] wd_limit  = wd_first ? CNT_W'(WD_STARTUP) : CNT_W'(WD_TIMEOUT);
  wire             wd_expire = wd_en && !rst_active && (wd_cnt == wd_limit);
  wire             fault_src = any_uv || !mr_db || wd_expire;
  wire             tmo_done  = ({1'b0, rst_cnt} + 1'b1) >= {1'b0, tmo};

  assign fault_n   = margin_n ? ~rail_uv : '1;
  assign sys_rst_n = margin_n ? !(rst_active || any_uv) : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mr_s1 <= 1'b1; mr_s2 <= 1'b1; mr_db <= 1'b1; db_cnt <= '0;
    end else begin
      mr_s1 <= mr_n;
      mr_s2 <= mr_s1;
      if (mr_s2 == mr_db) db_cnt <= '0;
      else if (db_cnt == DB_W'(DEBOUNCE - 1)) begin
        mr_db  <= mr_s2;
        db_cnt <= '0;
      end else db_cnt <= db_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w_s1 <= 1'b0; w_s2 <= 1'b0; w_s3 <= 1'b0;
    end else begin
      w_s1 <= wdi; w_s2 <= w_s1; w_s3 <= w_s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_active <= 1'b1; rst_cnt <= '0;
    end else if (fault_src) begin
      rst_active <= 1'b1; rst_cnt <= '0;
    end else if (rst_active) begin
      if (tmo_done) begin
        rst_active <= 1'b0; rst_cnt <= '0;
      end else rst_cnt <= rst_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_cnt <= '0; wd_first <= 1'b1;
    end else if (rst_active || !wd_en) begin
      wd_cnt <= '0; wd_first <= 1'b1;
    end else if (wd_edge) begin
      wd_cnt <= '0; wd_first <= 1'b0;
    end else if (!wd_expire) wd_cnt <= wd_cnt + 1'b1;

  a_r3_debounce_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mr_db) |-> mr_db == $past(mr_s2));
  a_r4_release_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active) |-> ($past(!fault_src) && $past(rst_active)));
  a_r8_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wd_edge && wd_en && !rst_active) |-> (wd_cnt == '0 && !wd_first));
  a_r9_cleared_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_active) |-> (wd_cnt == '0 && wd_first));
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wd_en) |-> (wd_cnt == '0));
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt <= CNT_W'(WD_STARTUP) || wd_cnt <= CNT_W'(WD_TIMEOUT));
endmodule

// File: tb/rail_supervisor_bench.sv
module rail_supervisor_bench;
  localparam int NR = 4, CW = 16, RT = 20, WT = 30, WS = 80, DB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] rail_uv = '0;
  logic mr_n = 1'b1, margin_n = 1'b1, wdi = 1'b0, wd_en = 1'b0, tmo_sel = 1'b0;
  logic [CW-1:0] tmo_prog = '0;
  logic [NR-1:0] fault_n;
  logic sys_rst_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rail_supervisor #(.NUM_RAILS(NR), .CNT_W(CW), .RST_TIMEOUT(RT),
    .WD_TIMEOUT(WT), .WD_STARTUP(WS), .DEBOUNCE(DB)) u_rail_supervisor (
    .clk(clk), .rst_n(rst_n), .rail_uv(rail_uv), .mr_n(mr_n), .margin_n(margin_n),
    .wdi(wdi), .wd_en(wd_en), .tmo_sel(tmo_sel), .tmo_prog(tmo_prog),
    .fault_n(fault_n), .sys_rst_n(sys_rst_n));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_to(input logic lvl, input int exp, input string tag);
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (sys_rst_n != lvl && n < exp + 50);
    chk(tag, n, exp);
  endtask

  task automatic rail_pulse(input logic [NR-1:0] v);
    @(negedge clk); rail_uv = v;
    repeat (3) @(negedge clk);
    rail_uv = '0;
  endtask

  task automatic t_powerup;
    #1; chk("R6 reset state sys_rst_n", sys_rst_n, 0);
    chk("R1 reset state fault_n", fault_n, 4'hF);
    @(negedge clk); rst_n = 1'b1;
    count_to(1'b1, RT, "R6 power-up hold");
  endtask

  task automatic t_rail;
    @(negedge clk); rail_uv = 4'b0100; #1;
    chk("R1 fault_n follows rail", fault_n, 4'b1011);
    chk("R2 reset on rail", sys_rst_n, 0);
    @(negedge clk); rail_uv = 4'b0000; #1;
    chk("R1 fault_n release", fault_n, 4'hF);
    count_to(1'b1, RT, "R4 rail stretch");
  endtask

  task automatic t_prog;
    tmo_sel = 1'b1; tmo_prog = 16'd7;
    rail_pulse(4'b0001);
    count_to(1'b1, 7, "R5 programmed timeout");
    tmo_prog = 16'd0;
    rail_pulse(4'b1000);
    count_to(1'b1, 1, "R5 zero acts as one");
    tmo_sel = 1'b0;
  endtask

  task automatic t_manual;
    int lo = 0;
    @(negedge clk); mr_n = 1'b0;
    repeat (2) @(negedge clk);
    mr_n = 1'b1;
    repeat (12) begin @(negedge clk); if (!sys_rst_n) lo++; end
    chk("R3 glitch ignored", lo, 0);
    mr_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 manual asserts", sys_rst_n, 0);
    mr_n = 1'b1;
    count_to(1'b1, 2 + DB + RT, "R4 manual release stretch");
  endtask

  task automatic t_margin;
    @(negedge clk); rail_uv = 4'hF; margin_n = 1'b0; #1;
    chk("R11 fault_n forced", fault_n, 4'hF);
    chk("R11 sys_rst_n forced", sys_rst_n, 1);
    @(negedge clk); margin_n = 1'b1; #1;
    chk("R2 reset after margin", sys_rst_n, 0);
    rail_uv = '0;
    count_to(1'b1, RT, "R4 after margin");
  endtask

  task automatic t_wd_off;
    int lo = 0;
    repeat (3 * WS) begin @(negedge clk); if (!sys_rst_n) lo++; end
    chk("R10 disabled watchdog", lo, 0);
  endtask

  task automatic t_watchdog;
    int lo = 0;
    wd_en = 1'b1;
    @(negedge clk); rail_uv = 4'b0010;
    repeat (3) begin repeat (2) @(negedge clk); wdi = ~wdi; end
    repeat (5) @(negedge clk);
    rail_uv = '0;
    count_to(1'b1, RT, "R4 before watchdog");
    count_to(1'b0, WS + 1, "R7 R9 startup window");
    count_to(1'b1, RT, "R12 watchdog stretch");
    wdi = ~wdi;
    count_to(1'b0, WT + 4, "R8 normal window after edge");
    count_to(1'b1, RT, "R12 watchdog stretch again");
    repeat (30) begin
      repeat (10) @(negedge clk);
      wdi = ~wdi;
      if (!sys_rst_n) lo++;
    end
    chk("R8 periodic kicks hold off reset", lo, 0);
    wd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_powerup;
    t_rail;
    t_prog;
    t_manual;
    t_margin;
    t_wd_off;
    t_watchdog;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule